// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block produces the two comparison pulses of a frequency synthesizer loop. On the fast input clock it models a dual-modulus prescaler, dividing by P+1 or P, and steers it with two counters. The swallow counter holds the prescaler at P+1 for its first A prescaler cycles. The main counter counts N prescaler cycles in total. One frame therefore lasts P·N + A input cycles and ends with a single-cycle `fp_o` pulse. On the reference clock, a separate counter divides by R and emits a single-cycle `fr_o` pulse. The loop then settles where f_in = (P·N + A)·f_ref / R.

The divide values and the prescaler modulus pair are sampled only when a frame or reference period begins. A host can therefore change them at any time without corrupting a count in progress. While the power-save input is high, both dividers stop and emit nothing. When it drops, both dividers reload from the inputs, so the two pulse trains start again from a common point.

Top module: `psd_divider`

## Requirements
- R1: With `mod_sel_i` = 1 (modulus pair 64/65, P = 64) or `mod_sel_i` = 0 (pair 128/129, P = 128), consecutive `fp_o` pulses are exactly P·N + A input-clock cycles apart, for N in 3..2047 and A in 0..127 with A < N.
- R2: Consecutive `fr_o` pulses are exactly R reference-clock cycles apart, for R in 3..16383.
- R3: Each `fp_o` and `fr_o` pulse is high for exactly one cycle of its own clock.
- R4: While `pwr_save_i` is high at a clock edge, the divider on that clock emits no pulse on the following cycle.
- R5: After reset is released, or after `pwr_save_i` falls, the first rising edge of each clock reloads that divider from the inputs. The first `fp_o` is then seen after P·N + A + 1 input-clock edges, and the first `fr_o` after R + 1 reference-clock edges, both counted from that reloading edge inclusive.
- R6: A change of `swallow_i`, `main_i`, `mod_sel_i` or `ref_i` during a running period does not alter that period. It takes effect from the next period onward.
- R7: While `rst_ni` is low, `fp_o` and `fr_o` are low.
- R8: Within a frame, the prescaler divides by P+1 for the first A prescaler cycles and by P for the rest. When a frame ends, the swallow count has run out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fin_i | input | 1 | Fast input clock (divided VCO signal) |
| clk_ref_i | input | 1 | Reference oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_save_i | input | 1 | Power save, active high; stops both dividers |
| mod_sel_i | input | 1 | Modulus pair: 1 = 64/65, 0 = 128/129 |
| swallow_i | input | 7 | Swallow count A |
| main_i | input | 11 | Main count N |
| ref_i | input | 14 | Reference divide ratio R |
| fp_o | output | 1 | Single-cycle pulse once per P·N + A input cycles |
| fr_o | output | 1 | Single-cycle pulse once per R reference cycles |

## Verification
The bench goes after the following corner cases:
- **Minimum main count.** With N = 3 and A = 0, an off-by-one in the main counter would shift the period by a whole prescaler cycle of 64 or 128.
- **Maximum swallow count.** With A = 127 and N = 128, a swallow counter that reloaded late, or kept extending cycles after the frame ended, would add extra P+1 cycles.
- **Reference extremes.** At the smallest ratio (3) and the largest (16383), a counter that wrapped or started at the wrong value would show up directly in the `fr_o` period.
- **Mid-period changes.** Changing A, N, the modulus and R in the middle of a period catches a design that applies new values immediately: it would shorten or stretch the running period.
- **Power-save window.** A held power-save window catches leaked pulses. The restart latency after the window catches dividers that resume from stale counts instead of reloading.

// File: rtl/psd_pkg.sv
package psd_pkg;

    localparam int unsigned DEF_A_W     = 7;
    localparam int unsigned DEF_N_W     = 11;
    localparam int unsigned DEF_R_W     = 14;
    localparam int unsigned DEF_P_SMALL = 64;

    // Modulus pair selection as seen on mod_sel_i
    typedef enum logic {
        MOD_WIDE   = 1'b0,   // 2P / 2P+1
        MOD_NARROW = 1'b1    // P / P+1
    } mod_sel_e;

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
    parameter int unsigned P_SMALL = psd_pkg::DEF_P_SMALL,
    parameter int unsigned PC_W    = $clog2(2 * P_SMALL + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic restart_i,
    input  logic wide_i,
    input  logic plus1_i,
    output logic tick_o
);

    localparam logic [PC_W-1:0] TERM_NARROW = PC_W'(P_SMALL - 1);
    localparam logic [PC_W-1:0] TERM_WIDE   = PC_W'(2 * P_SMALL - 1);

    typedef struct packed {
        logic [PC_W-1:0] phase;
    } pre_s;

    pre_s            st_d, st_q;
    logic [PC_W-1:0] term;

    always_comb begin
        term   = (wide_i ? TERM_WIDE : TERM_NARROW) + PC_W'(plus1_i);
        tick_o = run_i && (st_q.phase == term);
        st_d   = st_q;
        if (restart_i) begin
            st_d.phase = '0;
        end else if (run_i) begin
            st_d.phase = tick_o ? '0 : st_q.phase + PC_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/psd_swallow_cnt.sv
module psd_swallow_cnt #(
    parameter int unsigned A_W = psd_pkg::DEF_A_W
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           load_i,
    input  logic           reload_i,
    input  logic           tick_i,
    input  logic [A_W-1:0] a_in_i,
    output logic           plus1_o
);

    typedef struct packed {
        logic [A_W-1:0] left;
    } swl_s;

    swl_s st_d, st_q;

    always_comb begin
        plus1_o = (st_q.left != '0);
        st_d    = st_q;
        if (load_i || reload_i) begin
            st_d.left = a_in_i;
        end else if (tick_i && plus1_o) begin
            st_d.left = st_q.left - A_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/psd_main_cnt.sv
module psd_main_cnt #(
    parameter int unsigned N_W = psd_pkg::DEF_N_W
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           ps_i,
    input  logic           tick_i,
    input  logic           mod_sel_i,
    input  logic [N_W-1:0] n_in_i,
    output logic           run_o,
    output logic           restart_o,
    output logic           load_o,
    output logic           reload_o,
    output logic           wide_o,
    output logic           fp_o
);

    typedef struct packed {
        logic [N_W-1:0] left;
        logic           wide;
        logic           pend;
        logic           fp;
    } main_s;

    main_s st_d, st_q;
    logic  new_wide;

    always_comb begin
        new_wide  = (psd_pkg::mod_sel_e'(mod_sel_i) == psd_pkg::MOD_WIDE);
        run_o     = !ps_i && !st_q.pend;
        restart_o = ps_i || st_q.pend;
        load_o    = !ps_i && st_q.pend;
        reload_o  = tick_i && (st_q.left == N_W'(1));
        wide_o    = st_q.wide;
        fp_o      = st_q.fp;

        st_d    = st_q;
        st_d.fp = 1'b0;
        if (ps_i) begin
            st_d.pend = 1'b1;
        end else if (st_q.pend) begin
            st_d.pend = 1'b0;
            st_d.left = n_in_i;
            st_d.wide = new_wide;
        end else if (reload_o) begin
            st_d.left = n_in_i;
            st_d.wide = new_wide;
            st_d.fp   = 1'b1;
        end else if (tick_i) begin
            st_d.left = st_q.left - N_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.pend <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/psd_ref_div.sv
module psd_ref_div #(
    parameter int unsigned R_W = psd_pkg::DEF_R_W
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           ps_i,
    input  logic [R_W-1:0] r_in_i,
    output logic           fr_o
);

    typedef struct packed {
        logic [R_W-1:0] left;
        logic           pend;
        logic           fr;
    } ref_s;

    ref_s st_d, st_q;

    always_comb begin
        fr_o    = st_q.fr;
        st_d    = st_q;
        st_d.fr = 1'b0;
        if (ps_i) begin
            st_d.pend = 1'b1;
        end else if (st_q.pend) begin
            st_d.pend = 1'b0;
            st_d.left = r_in_i;
        end else if (st_q.left == R_W'(1)) begin
            st_d.left = r_in_i;
            st_d.fr   = 1'b1;
        end else begin
            st_d.left = st_q.left - R_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.pend <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/psd_divider.sv
module psd_divider #(
    parameter int unsigned A_W     = psd_pkg::DEF_A_W,
    parameter int unsigned N_W     = psd_pkg::DEF_N_W,
    parameter int unsigned R_W     = psd_pkg::DEF_R_W,
    parameter int unsigned P_SMALL = psd_pkg::DEF_P_SMALL
) (
    input  logic           clk_fin_i,
    input  logic           clk_ref_i,
    input  logic           rst_ni,
    input  logic           pwr_save_i,
    input  logic           mod_sel_i,
    input  logic [A_W-1:0] swallow_i,
    input  logic [N_W-1:0] main_i,
    input  logic [R_W-1:0] ref_i,
    output logic           fp_o,
    output logic           fr_o
);

    localparam int unsigned PC_W = $clog2(2 * P_SMALL + 1);

    logic pre_tick;
    logic run;
    logic restart;
    logic load;
    logic reload;
    logic wide;
    logic plus1;

    psd_prescaler #(.P_SMALL(P_SMALL), .PC_W(PC_W)) i_pre (
        .clk_i     (clk_fin_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .restart_i (restart),
        .wide_i    (wide),
        .plus1_i   (plus1),
        .tick_o    (pre_tick)
    );

    psd_swallow_cnt #(.A_W(A_W)) i_swl (
        .clk_i    (clk_fin_i),
        .rst_ni   (rst_ni),
        .load_i   (load),
        .reload_i (reload),
        .tick_i   (pre_tick),
        .a_in_i   (swallow_i),
        .plus1_o  (plus1)
    );

    psd_main_cnt #(.N_W(N_W)) i_main (
        .clk_i     (clk_fin_i),
        .rst_ni    (rst_ni),
        .ps_i      (pwr_save_i),
        .tick_i    (pre_tick),
        .mod_sel_i (mod_sel_i),
        .n_in_i    (main_i),
        .run_o     (run),
        .restart_o (restart),
        .load_o    (load),
        .reload_o  (reload),
        .wide_o    (wide),
        .fp_o      (fp_o)
    );

    psd_ref_div #(.R_W(R_W)) i_ref (
        .clk_i  (clk_ref_i),
        .rst_ni (rst_ni),
        .ps_i   (pwr_save_i),
        .r_in_i (ref_i),
        .fr_o   (fr_o)
    );

endmodule

// File: rtl/psd_divider_chk.sv
module psd_divider_chk (
    input logic clk_fin,
    input logic clk_ref,
    input logic rst_n,
    input logic ps,
    input logic fp,
    input logic fr,
    input logic tick,
    input logic reload,
    input logic plus1
);

    p_fp_single_r3: assert property (@(posedge clk_fin) disable iff (!rst_n)
        fp |=> !fp);

    p_fr_single_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        fr |=> !fr);

    p_fp_quiet_r4: assert property (@(posedge clk_fin) disable iff (!rst_n)
        ps |=> !fp);

    p_fr_quiet_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ps |=> !fr);

    p_swallow_spent_r8: assert property (@(posedge clk_fin) disable iff (!rst_n)
        reload |-> !plus1);

    p_pulse_follows_reload_r1: assert property (@(posedge clk_fin) disable iff (!rst_n)
        (reload && tick) |=> fp);

endmodule

bind psd_divider psd_divider_chk i_chk (
    .clk_fin (clk_fin_i),
    .clk_ref (clk_ref_i),
    .rst_n   (rst_ni),
    .ps      (pwr_save_i),
    .fp      (fp_o),
    .fr      (fr_o),
    .tick    (pre_tick),
    .reload  (reload),
    .plus1   (plus1)
);

// File: tb/test_psd_divider.sv
module test_psd_divider;

    logic        clk_fin = 1'b0;
    logic        clk_ref = 1'b0;
    logic        rst_n;
    logic        ps;
    logic        msel;
    logic [6:0]  a_in;
    logic [10:0] n_in;
    logic [13:0] r_in;
    logic        fp;
    logic        fr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // mode, A, N, R, expected fp period
    localparam int NV = 6;
    localparam int VEC [NV][5] = '{
        '{1,   0,   3,     3,  192},
        '{1,   5,   7,    10,  453},
        '{0,   2,   3,    17,  386},
        '{1, 127, 128,    64, 8319},
        '{1,   2,   3, 16383,  194},
        '{0,   0,   4,   100,  512}
    };

    psd_divider i_psd_divider (
        .clk_fin_i  (clk_fin),
        .clk_ref_i  (clk_ref),
        .rst_ni     (rst_n),
        .pwr_save_i (ps),
        .mod_sel_i  (msel),
        .swallow_i  (a_in),
        .main_i     (n_in),
        .ref_i      (r_in),
        .fp_o       (fp),
        .fr_o       (fr)
    );

    always #5 clk_fin = ~clk_fin;
    always #5 clk_ref = ~clk_ref;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk_fin) begin
        cyc = cyc + 1;
        if (cyc == 190000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_fp(output int cnt, output int first);
        cnt = 0;
        first = 0;
        while (1) begin
            @(posedge clk_fin);
            cnt++;
            @(negedge clk_fin);
            if (cnt == 1) first = int'(fp);
            if (fp || cnt >= 40000) break;
        end
    endtask

    task automatic wait_fr(output int cnt, output int first);
        cnt = 0;
        first = 0;
        while (1) begin
            @(posedge clk_ref);
            cnt++;
            @(negedge clk_ref);
            if (cnt == 1) first = int'(fr);
            if (fr || cnt >= 40000) break;
        end
    endtask

    task automatic apply(input int v);
        msel = VEC[v][0][0];
        a_in = 7'(VEC[v][1]);
        n_in = 11'(VEC[v][2]);
        r_in = 14'(VEC[v][3]);
    endtask

    int c_fp0, c_fp1, f_fp, c_fr0, c_fr1, f_fr, hits, p_a, p_b, q_a, q_b, dummy;

    initial begin
        rst_n = 1'b0;
        ps    = 1'b0;
        apply(0);

        // R7: outputs low throughout reset
        repeat (4) @(negedge clk_fin);
        check_eq("R7", "fp in reset", int'(fp), 0);
        check_eq("R7", "fr in reset", int'(fr), 0);
        rst_n = 1'b1;

        // R5: first pulses after reset release
        fork
            wait_fp(c_fp0, dummy);
            wait_fr(c_fr0, dummy);
        join
        check_eq("R5", "first fp after reset", c_fp0, 193);
        check_eq("R5", "first fr after reset", c_fr0, 4);

        // R4: power save suppresses both pulse trains
        @(negedge clk_fin);
        ps = 1'b1;
        hits = 0;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk_fin);
            if (fp || fr) hits++;
        end
        check_eq("R4", "pulses during power save", hits, 0);

        // Table walk: R5 restart latency, R1/R8 and R2 periods, R3 width
        for (int v = 0; v < NV; v++) begin
            ps = 1'b1;
            apply(v);
            repeat (3) @(negedge clk_fin);
            ps = 1'b0;
            fork
                begin
                    wait_fp(c_fp0, dummy);
                    wait_fp(c_fp1, f_fp);
                end
                begin
                    wait_fr(c_fr0, dummy);
                    wait_fr(c_fr1, f_fr);
                end
            join
            check_eq("R5", $sformatf("vec %0d first fp", v), c_fp0, VEC[v][4] + 1);
            check_eq("R5", $sformatf("vec %0d first fr", v), c_fr0, VEC[v][3] + 1);
            check_eq(VEC[v][1] > 0 ? "R8" : "R1", $sformatf("vec %0d fp period", v), c_fp1, VEC[v][4]);
            check_eq("R2", $sformatf("vec %0d fr period", v), c_fr1, VEC[v][3]);
            check_eq("R3", $sformatf("vec %0d fp width", v), f_fp, 0);
            check_eq("R3", $sformatf("vec %0d fr width", v), f_fr, 0);
        end

        // R6: values changed mid-period apply only from the next period
        @(negedge clk_fin);
        ps = 1'b1;
        msel = 1'b1; a_in = 7'd0; n_in = 11'd3; r_in = 14'd20;
        repeat (3) @(negedge clk_fin);
        ps = 1'b0;
        fork
            begin
                wait_fp(c_fp0, dummy);
                fork
                    wait_fp(p_a, dummy);
                    begin
                        repeat (40) @(negedge clk_fin);
                        msel = 1'b0; a_in = 7'd1; n_in = 11'd5;
                    end
                join
                wait_fp(p_b, dummy);
            end
            begin
                wait_fr(c_fr0, dummy);
                fork
                    wait_fr(q_a, dummy);
                    begin
                        repeat (5) @(negedge clk_ref);
                        r_in = 14'd7;
                    end
                join
                wait_fr(q_b, dummy);
            end
        join
        check_eq("R6", "fp period during change", p_a, 192);
        check_eq("R6", "fp period after change", p_b, 641);
        check_eq("R6", "fr period during change", q_a, 20);
        check_eq("R6", "fr period after change", q_b, 7);

        summary();
        $finish;
    end

endmodule